// File: doc/BRIEF.md
# Converter Output Test Pattern Generator

This block sits on the 16-bit word stream leaving a data converter. In normal operation it passes each sample through unchanged. Once a test pattern is selected through a small byte-wide register port, it substitutes a pattern for every word it accepts. The pattern can be one of several fixed presets, or one or two user words held in the same register file. Some patterns are static and some alternate between two words on successive output words. The input samples keep flowing and are still consumed while a pattern is shown, so the upstream converter never stalls because of a test mode.

The register port runs on its own configuration clock, which has no relation to the sample clock. Each mapped write marks the register contents dirty. A snapshot of the whole configuration then crosses into the sample domain through a toggle request/acknowledge handshake with synchronisers. The sample side holds the received snapshot as pending. It installs the snapshot on the next word it accepts, so a pattern appears only some sample cycles after the write, and never in the middle of a word. Both stream interfaces are valid/ready. An input word is taken only when `s_valid` and `s_ready` are both high. `s_ready` is high whenever the single output register is empty or is being drained in the same cycle. A word held with `m_valid` high and `m_ready` low stays on `m_data` unchanged until it is taken.

Top module: `conv_test_pattern`

## Requirements
- R1: After reset, `m_valid` is low, `s_ready` is high, and the configuration is "off", so the first accepted word is output unchanged.
- R2: Bits 3:0 of the control register at BASE_ADDR (0xC0) select the pattern. Code 0000 and every code not listed in R3, R4 and R5 (0101, 0110, 1001 to 1111) pass the input word through unchanged.
- R3: Code 0001 outputs 0x8000, code 0010 outputs 0xFFFF and code 0011 outputs 0x0000 on every word.
- R4: Code 0100 alternates 0xAAAA and 0x5555, and code 0111 alternates 0xFFFF and 0x0000, in each case starting with the first word named.
- R5: Code 1000 selects the user words, with bits 7:6 of the control register choosing the behaviour. 00 outputs user word 1 on every word, 01 alternates word 1 and word 2 starting with word 1, and 10 and 11 behave like 00.
- R6: User word 1 is written at BASE_ADDR+2 (bits 7:0) and BASE_ADDR+3 (bits 15:8). User word 2 is written at BASE_ADDR+4 (bits 7:0) and BASE_ADDR+5 (bits 15:8).
- R7: A write to any other address, including BASE_ADDR+1, changes no output word and does not restart the alternation.
- R8: The configuration reaches the sample domain as a whole snapshot. When writes arrive back to back, the values of the last write always take effect.
- R9: A received configuration is applied to the first word accepted after it arrives. Every applied configuration restarts the alternation at its first word.
- R10: An output word is valid one sample cycle after it is accepted. While `m_valid` is high and `m_ready` is low, `m_data` holds steady and `s_ready` is low.
- R11: The alternation advances only on accepted words, so a stall never skips a pattern word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Register port clock |
| cfg_rst_n | input | 1 | Active-low reset, register domain |
| cfg_we | input | 1 | Byte write strobe |
| cfg_addr | input | 8 | Write address |
| cfg_wdata | input | 8 | Write data byte |
| smp_clk | input | 1 | Sample clock |
| smp_rst_n | input | 1 | Active-low reset, sample domain |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Block can take an input sample |
| s_data | input | 16 | Input sample word |
| m_valid | output | 1 | Output word valid |
| m_ready | input | 1 | Downstream takes the output word |
| m_data | output | 16 | Output word, either a sample or a pattern |

## Verification
The bench builds the block with its default parameters: a 16-bit word, base address 0xC0 and two synchroniser stages. With these values every preset code, both user-word byte lanes and the reserved codes can be reached by 8-bit writes. The configuration clock runs at 7 ns against the 10 ns sample clock, so the handshake crosses between unrelated phases. The two-stage synchronisers keep the write-to-pattern latency short enough that back-to-back bursts of five writes still settle between test cases.

// File: rtl/ctp_pkg.sv
package ctp_pkg;
  localparam logic [3:0] CODE_OFF     = 4'h0;
  localparam logic [3:0] CODE_MID     = 4'h1;
  localparam logic [3:0] CODE_POSFS   = 4'h2;
  localparam logic [3:0] CODE_NEGFS   = 4'h3;
  localparam logic [3:0] CODE_CHECK   = 4'h4;
  localparam logic [3:0] CODE_ONEZERO = 4'h7;
  localparam logic [3:0] CODE_USER    = 4'h8;

  localparam logic [1:0] USEL_STATIC  = 2'b00;
  localparam logic [1:0] USEL_ALT     = 2'b01;

  typedef struct packed {
    logic [1:0] usel;
    logic [3:0] code;
  } ctl_t;

  localparam ctl_t CTL_RESET = '{usel: USEL_STATIC, code: CODE_OFF};
endpackage

// File: rtl/ctp_sync.sv
module ctp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ctp_cfg_regs.sv
module ctp_cfg_regs
  import ctp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'hC0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              ack_sync,
  output logic              req_tgl,
  output ctl_t              xfer_ctl,
  output logic [DATA_W-1:0] xfer_w1,
  output logic [DATA_W-1:0] xfer_w2
);
  localparam int BYTES = DATA_W / 8;
  localparam logic [ADDR_W-1:0] W1_ADDR = BASE_ADDR + ADDR_W'(2);
  localparam logic [ADDR_W-1:0] W2_ADDR = BASE_ADDR + ADDR_W'(2 + BYTES);

  ctl_t              ctl_q;
  logic [DATA_W-1:0] w1_q, w2_q, w1_d, w2_d;
  logic [BYTES-1:0]  hit1, hit2;
  logic              hit_ctl, mapped, idle, launch, dirty_q;

  assign hit_ctl = we && (addr == BASE_ADDR);

  generate
    for (genvar b = 0; b < BYTES; b++) begin : g_lane
      assign hit1[b] = we && (addr == W1_ADDR + ADDR_W'(b));
      assign hit2[b] = we && (addr == W2_ADDR + ADDR_W'(b));
      always_comb begin
        w1_d[8*b +: 8] = hit1[b] ? wdata : w1_q[8*b +: 8];
        w2_d[8*b +: 8] = hit2[b] ? wdata : w2_q[8*b +: 8];
      end
    end
  endgenerate

  assign mapped = hit_ctl || (|hit1) || (|hit2);
  assign idle   = (req_tgl == ack_sync);
  assign launch = idle && dirty_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= CTL_RESET;
      w1_q  <= '0;
      w2_q  <= '0;
    end else begin
      if (hit_ctl) ctl_q <= '{usel: wdata[7:6], code: wdata[3:0]};
      w1_q <= w1_d;
      w2_q <= w2_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirty_q  <= 1'b0;
      req_tgl  <= 1'b0;
      xfer_ctl <= CTL_RESET;
      xfer_w1  <= '0;
      xfer_w2  <= '0;
    end else begin
      if (mapped)      dirty_q <= 1'b1;
      else if (launch) dirty_q <= 1'b0;
      if (launch) begin
        xfer_ctl <= ctl_q;
        xfer_w1  <= w1_q;
        xfer_w2  <= w2_q;
        req_tgl  <= ~req_tgl;
      end
    end
  end

  // The snapshot must stay frozen while the other domain may be sampling it.
  assert_xfer_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_tgl != ack_sync) |=> ($stable(xfer_ctl) && $stable(xfer_w1) && $stable(xfer_w2)));
  // A pending change is never dropped: once dirty, a launch follows when idle.
  assert_dirty_launch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dirty_q && idle && !mapped) |=> (!dirty_q && !idle));
endmodule

// File: rtl/ctp_cfg_rx.sv
module ctp_cfg_rx
  import ctp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_sync,
  input  ctl_t              xfer_ctl,
  input  logic [DATA_W-1:0] xfer_w1,
  input  logic [DATA_W-1:0] xfer_w2,
  input  logic              take,
  output logic              ack_tgl,
  output logic              pend,
  output ctl_t              stg_ctl,
  output logic [DATA_W-1:0] stg_w1,
  output logic [DATA_W-1:0] stg_w2
);
  logic capture;
  assign capture = (req_sync != ack_tgl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_tgl <= 1'b0;
      pend    <= 1'b0;
      stg_ctl <= CTL_RESET;
      stg_w1  <= '0;
      stg_w2  <= '0;
    end else begin
      if (capture) begin
        stg_ctl <= xfer_ctl;
        stg_w1  <= xfer_w1;
        stg_w2  <= xfer_w2;
        ack_tgl <= req_sync;
      end
      if (capture)   pend <= 1'b1;
      else if (take) pend <= 1'b0;
    end
  end

  // A received configuration waits until a word consumes it.
  assert_pend_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !take && !capture) |=> pend);
  assert_pend_taken_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && take && !capture) |=> !pend);
endmodule

// File: rtl/ctp_pattern_gen.sv
module ctp_pattern_gen
  import ctp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pend,
  input  ctl_t              stg_ctl,
  input  logic [DATA_W-1:0] stg_w1,
  input  logic [DATA_W-1:0] stg_w2,
  output logic              take,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data
);
  localparam logic [DATA_W-1:0] PAT_MID  = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] PAT_CHK0 = {(DATA_W/2){2'b10}};
  localparam logic [DATA_W-1:0] PAT_CHK1 = {(DATA_W/2){2'b01}};

  ctl_t              act_ctl, use_ctl;
  logic [DATA_W-1:0] act_w1, act_w2, use_w1, use_w2, word;
  logic              phase_q, use_phase, accept, alt;

  assign accept    = s_valid && s_ready;
  assign s_ready   = !m_valid || m_ready;
  assign take      = accept && pend;
  assign use_ctl   = pend ? stg_ctl : act_ctl;
  assign use_w1    = pend ? stg_w1  : act_w1;
  assign use_w2    = pend ? stg_w2  : act_w2;
  assign use_phase = pend ? 1'b0    : phase_q;

  always_comb begin
    alt  = 1'b0;
    word = s_data;
    case (use_ctl.code)
      CODE_MID:     word = PAT_MID;
      CODE_POSFS:   word = '1;
      CODE_NEGFS:   word = '0;
      CODE_CHECK: begin
        alt  = 1'b1;
        word = use_phase ? PAT_CHK1 : PAT_CHK0;
      end
      CODE_ONEZERO: begin
        alt  = 1'b1;
        word = use_phase ? '0 : '1;
      end
      CODE_USER: begin
        alt  = (use_ctl.usel == USEL_ALT);
        word = (alt && use_phase) ? use_w2 : use_w1;
      end
      default:      word = s_data;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_ctl <= CTL_RESET;
      act_w1  <= '0;
      act_w2  <= '0;
      phase_q <= 1'b0;
      m_valid <= 1'b0;
      m_data  <= '0;
    end else begin
      if (accept) begin
        m_data  <= word;
        phase_q <= alt ? ~use_phase : 1'b0;
        if (pend) begin
          act_ctl <= stg_ctl;
          act_w1  <= stg_w1;
          act_w2  <= stg_w2;
        end
      end
      if (accept)       m_valid <= 1'b1;
      else if (m_ready) m_valid <= 1'b0;
    end
  end

  assert_hold_on_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));
  assert_accept_shows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> m_valid);
  assert_midscale_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && use_ctl.code == CODE_MID) |=> (m_data == PAT_MID));
  assert_phase_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(phase_q));
endmodule

// File: rtl/conv_test_pattern.sv
module conv_test_pattern
  import ctp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'hC0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              cfg_clk,
  input  logic              cfg_rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              smp_clk,
  input  logic              smp_rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data
);
  ctl_t              xfer_ctl, stg_ctl;
  logic [DATA_W-1:0] xfer_w1, xfer_w2, stg_w1, stg_w2;
  logic              req_tgl, req_sync, ack_tgl, ack_sync, pend, take;

  ctp_cfg_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_regs (
    .clk(cfg_clk), .rst_n(cfg_rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .ack_sync(ack_sync), .req_tgl(req_tgl),
    .xfer_ctl(xfer_ctl), .xfer_w1(xfer_w1), .xfer_w2(xfer_w2)
  );

  ctp_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(smp_clk), .rst_n(smp_rst_n), .d(req_tgl), .q(req_sync)
  );

  ctp_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(cfg_clk), .rst_n(cfg_rst_n), .d(ack_tgl), .q(ack_sync)
  );

  ctp_cfg_rx #(.DATA_W(DATA_W)) u_rx (
    .clk(smp_clk), .rst_n(smp_rst_n), .req_sync(req_sync),
    .xfer_ctl(xfer_ctl), .xfer_w1(xfer_w1), .xfer_w2(xfer_w2),
    .take(take), .ack_tgl(ack_tgl), .pend(pend),
    .stg_ctl(stg_ctl), .stg_w1(stg_w1), .stg_w2(stg_w2)
  );

  ctp_pattern_gen #(.DATA_W(DATA_W)) u_gen (
    .clk(smp_clk), .rst_n(smp_rst_n), .pend(pend),
    .stg_ctl(stg_ctl), .stg_w1(stg_w1), .stg_w2(stg_w2), .take(take),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
  );
endmodule

// File: tb/conv_test_pattern_tb.sv
module conv_test_pattern_tb;
  logic        cfg_clk = 1'b0, smp_clk = 1'b0;
  logic        cfg_rst_n = 1'b0, smp_rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0, cfg_wdata = '0;
  logic        s_valid = 1'b0, m_ready = 1'b1;
  logic [15:0] s_data = '0;
  logic        s_ready, m_valid;
  logic [15:0] m_data;
  int          n_chk = 0, n_bad = 0;
  logic        done = 1'b0;

  always #5   smp_clk = ~smp_clk;
  always #3.5 cfg_clk = ~cfg_clk;

  conv_test_pattern u_dut (
    .cfg_clk(cfg_clk), .cfg_rst_n(cfg_rst_n), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .smp_clk(smp_clk), .smp_rst_n(smp_rst_n),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
  );

  typedef struct packed {
    logic [7:0]  ctl;
    logic [15:0] w1, w2, din, e0, e1;
    logic        pass;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 16'h0000, 16'h0000, 16'h1000, 16'h0000, 16'h0000, 1'b1},
    '{8'h01, 16'h0000, 16'h0000, 16'h2000, 16'h8000, 16'h8000, 1'b0},
    '{8'h02, 16'h0000, 16'h0000, 16'h3000, 16'hFFFF, 16'hFFFF, 1'b0},
    '{8'h03, 16'h0000, 16'h0000, 16'h4000, 16'h0000, 16'h0000, 1'b0},
    '{8'h04, 16'h0000, 16'h0000, 16'h5000, 16'hAAAA, 16'h5555, 1'b0},
    '{8'h07, 16'h0000, 16'h0000, 16'h6000, 16'hFFFF, 16'h0000, 1'b0},
    '{8'h05, 16'h0000, 16'h0000, 16'h7000, 16'h0000, 16'h0000, 1'b1},
    '{8'h06, 16'h0000, 16'h0000, 16'h7100, 16'h0000, 16'h0000, 1'b1},
    '{8'h08, 16'h1234, 16'hABCD, 16'h8000, 16'h1234, 16'h1234, 1'b0},
    '{8'h48, 16'hC35A, 16'h0F96, 16'h9000, 16'hC35A, 16'h0F96, 1'b0},
    '{8'h88, 16'h2468, 16'h1357, 16'hA000, 16'h2468, 16'h2468, 1'b0},
    '{8'h0C, 16'h0000, 16'h0000, 16'hB000, 16'h0000, 16'h0000, 1'b1},
    '{8'hC8, 16'h7E81, 16'h0001, 16'hC000, 16'h7E81, 16'h7E81, 1'b0}
  };

  function automatic string tag_of(input logic [7:0] c);
    case (c[3:0])
      4'h1, 4'h2, 4'h3: return "R3";
      4'h4, 4'h7:       return "R4";
      4'h8:             return "R5/R6";
      default:          return "R2";
    endcase
  endfunction

  task automatic check16(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge cfg_clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge cfg_clk);
    cfg_we = 1'b0;
  endtask

  task automatic settle();
    repeat (40) @(negedge smp_clk);
  endtask

  task automatic send_word(input logic [15:0] din, input logic [15:0] exp, input string tag);
    @(negedge smp_clk);
    s_valid = 1'b1; s_data = din;
    @(negedge smp_clk);
    s_valid = 1'b0;
    check16({15'd0, m_valid}, 16'd1, {tag, " valid"});
    check16(m_data, exp, tag);
  endtask

  task automatic load_cfg(input vec_t v);
    cfg_write(8'hC2, v.w1[7:0]);
    cfg_write(8'hC3, v.w1[15:8]);
    cfg_write(8'hC4, v.w2[7:0]);
    cfg_write(8'hC5, v.w2[15:8]);
    cfg_write(8'hC0, v.ctl);
    settle();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge smp_clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    repeat (4) @(negedge smp_clk);
    cfg_rst_n = 1'b1; smp_rst_n = 1'b1;
    @(negedge smp_clk);
    // R1: reset state and pass-through of the first word
    check16({15'd0, m_valid}, 16'd0, "R1 m_valid");
    check16({15'd0, s_ready}, 16'd1, "R1 s_ready");
    send_word(16'h1357, 16'h1357, "R1");

    // Table walk: every code, both user modes, byte lanes (R2..R6, R8, R9)
    for (int i = 0; i < NV; i++) begin
      load_cfg(VECS[i]);
      for (int k = 0; k < 4; k++) begin
        logic [15:0] din, ex;
        din = 16'(VECS[i].din + 16'(k));
        ex  = VECS[i].pass ? din : ((k % 2 == 0) ? VECS[i].e0 : VECS[i].e1);
        send_word(din, ex, tag_of(VECS[i].ctl));
      end
    end

    // R7: unmapped writes neither change the pattern nor restart the phase
    cfg_write(8'hC0, 8'h04);
    settle();
    send_word(16'h0001, 16'hAAAA, "R7");
    cfg_write(8'hC1, 8'h08);
    cfg_write(8'h00, 8'h01);
    settle();
    send_word(16'h0002, 16'h5555, "R7");

    // R9: rewriting the same mode restarts alternation at word 1
    send_word(16'h0003, 16'hAAAA, "R9");
    cfg_write(8'hC0, 8'h04);
    settle();
    send_word(16'h0004, 16'hAAAA, "R9");

    // R8: back-to-back control writes, last one wins
    cfg_write(8'hC0, 8'h01);
    cfg_write(8'hC0, 8'h03);
    cfg_write(8'hC0, 8'h02);
    settle();
    send_word(16'h0005, 16'hFFFF, "R8");

    // R10/R11: stall holds data, blocks input, keeps phase
    cfg_write(8'hC0, 8'h07);
    settle();
    m_ready = 1'b0;
    @(negedge smp_clk);
    s_valid = 1'b1; s_data = 16'h0010;
    @(negedge smp_clk);
    s_data = 16'h0011;
    repeat (3) @(negedge smp_clk);
    check16(m_data, 16'hFFFF, "R10 hold");
    check16({15'd0, s_ready}, 16'd0, "R10 s_ready");
    m_ready = 1'b1;
    @(negedge smp_clk);
    s_valid = 1'b0;
    check16(m_data, 16'h0000, "R11");
    send_word(16'h0012, 16'hFFFF, "R11");

    // back to pass-through
    cfg_write(8'hC0, 8'h00);
    settle();
    send_word(16'hBEEF, 16'hBEEF, "R2");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule